// File: doc/BRIEF.md
# Four-Mode Timer/Counter Channel

This block is one timer/counter channel with an 8-bit low count byte and an 8-bit high count byte. Software writes both bytes, a mode byte and a control byte through a small write port, and reads all of them back. The channel advances either on an internal tick strobe or, in counter operation, on rising edges seen on an external count pin. When gating is enabled, a second external pin must be high for counting to occur.

Four counting arrangements are selectable. The first is a 13-bit counter made of a 5-bit prescaler in the low byte feeding the high byte. The second is a 16-bit counter. The third is an 8-bit counter in the low byte that reloads from the high byte. The fourth is a split arrangement in which the low byte counts for this channel. In that arrangement the high byte counts internal ticks under a neighbouring channel's run bit and reports its wrap to that neighbour. The sticky overflow flag is meant to drive an interrupt request.

Top module: `tmr_quad`

## Requirements
- R1: After reset the low byte, high byte, mode byte, run bit, overflow flag and neighbour overflow pulse are all zero.
- R2: A write with wr_sel_i 0, 1, 2 or 3 loads the low byte, high byte, mode byte or control byte, and the value reads back on the next cycle. In the mode byte, bits [1:0] select the arrangement (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split), bit 2 selects the external count pin and bit 3 enables gating. In the control byte, bit 0 is the run bit and bit 1 is the overflow flag.
- R3: While the run bit is clear, neither byte changes. The split-mode high byte is the exception: it follows run_b_i.
- R4: With gating enabled, no increment occurs while the synchronized gate pin is low. Once it is high, counting proceeds.
- R5: With the count-pin select set, each synchronized rising edge of cnt_pin_i produces exactly one increment and tick_i is ignored. An edge that cannot yet be used stays pending until it is consumed.
- R6: Any write to the mode byte discards a pending count-pin edge.
- R7: In 13-bit operation the low 5 bits of the low byte act as a prescaler. When they roll over, the low byte becomes zero and the high byte increments. A high-byte wrap from 0xFF to 0x00 sets the overflow flag.
- R8: In 16-bit operation the two bytes count as one value, and a wrap from 0xFFFF to 0x0000 sets the overflow flag.
- R9: In 8-bit reload operation only the low byte counts. On a wrap it is loaded with the high byte and the overflow flag is set. The high byte is never changed by counting.
- R10: In split operation the low byte is an 8-bit counter under this channel's run, gate and source settings and sets this channel's flag on wrap. The high byte counts ticks while run_b_i is high, and on its 0xFF to 0x00 wrap ovf_b_o pulses high for one cycle. Outside split operation ovf_b_o stays low.
- R11: In split operation the high byte keeps counting while gating blocks the low byte.
- R12: The overflow flag stays set until a control write clears it. A hardware set in the same cycle as a clearing write wins. A write to either count byte takes effect instead of counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 low, 1 high, 2 mode, 3 control |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | Internal count strobe |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| gate_pin_i | input | 1 | External gate pin, asynchronous |
| run_b_i | input | 1 | Neighbour channel run bit, used by the split high byte |
| tl_o | output | 8 | Low count byte |
| th_o | output | 8 | High count byte |
| mode_o | output | 8 | Mode byte |
| run_o | output | 1 | Run bit |
| ovf_o | output | 1 | Sticky overflow flag, interrupt request |
| ovf_b_o | output | 1 | One-cycle wrap pulse for the neighbour's flag |

## Verification
A wrong count step shows on tl_o and th_o on the cycle after the tick that caused it. A mis-decoded arrangement therefore becomes visible at the first prescaler rollover, wrap or reload. A stale pending-edge bit does not appear until run is set again: it shows up as one extra count roughly three cycles after the synchronizer settles. A lost or spurious flag shows on ovf_o one cycle after the wrap and persists, because the flag is sticky. A split-mode fault shows as an ovf_b_o pulse that is missing or misplaced relative to th_o reaching zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_PRE13   = 2'd0,
    MD_WIDE16  = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_SPLIT   = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_MODE = 2'd2,
    SEL_CTRL = 2'd3
  } tmr_sel_e;

  localparam int MB_CSEL = 2;
  localparam int MB_GATE = 3;
  localparam int CB_RUN  = 0;
  localparam int CB_FLAG = 1;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tmr_rise.sv
module tmr_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PRE_BITS = 5
) (
  input  tmr_mode_e      mode_i,
  input  logic [DW-1:0]  tl_i,
  input  logic [DW-1:0]  th_i,
  input  logic           inc_a_i,
  input  logic           inc_b_i,
  output logic [DW-1:0]  tl_o,
  output logic [DW-1:0]  th_o,
  output logic           set_a_o,
  output logic           set_b_o
);
  localparam logic [DW-1:0]   ONE   = DW'(1);
  localparam logic [2*DW-1:0] ONE2  = (2*DW)'(1);
  localparam logic [DW-1:0]   ALL1  = '1;

  logic [DW-1:0]   tl_inc, th_inc;
  logic [2*DW-1:0] wide_inc;

  assign tl_inc   = tl_i + ONE;
  assign th_inc   = th_i + ONE;
  assign wide_inc = {th_i, tl_i} + ONE2;

  always_comb begin
    tl_o    = tl_i;
    th_o    = th_i;
    set_a_o = 1'b0;
    set_b_o = 1'b0;
    unique case (mode_i)
      MD_PRE13: if (inc_a_i) begin
        if (tl_inc[PRE_BITS-1:0] == '0) begin
          tl_o    = '0;
          th_o    = th_inc;
          set_a_o = (th_i == ALL1);
        end else begin
          tl_o = tl_inc;
        end
      end
      MD_WIDE16: if (inc_a_i) begin
        {th_o, tl_o} = wide_inc;
        set_a_o      = ({th_i, tl_i} == {ALL1, ALL1});
      end
      MD_RELOAD8: if (inc_a_i) begin
        if (tl_i == ALL1) begin
          tl_o    = th_i;
          set_a_o = 1'b1;
        end else begin
          tl_o = tl_inc;
        end
      end
      MD_SPLIT: begin
        if (inc_a_i) begin
          tl_o    = tl_inc;
          set_a_o = (tl_i == ALL1);
        end
        if (inc_b_i) begin
          th_o    = th_inc;
          set_b_o = (th_i == ALL1);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad
  import tmr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int PRE_BITS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          tick_i,
  input  logic          cnt_pin_i,
  input  logic          gate_pin_i,
  input  logic          run_b_i,
  output logic [DW-1:0] tl_o,
  output logic [DW-1:0] th_o,
  output logic [DW-1:0] mode_o,
  output logic          run_o,
  output logic          ovf_o,
  output logic          ovf_b_o
);
  logic [DW-1:0] tl_q, th_q, mode_q, tl_n, th_n;
  logic          run_q, flag_q, pend_q, ovf_b_q;
  logic [1:0]    pin_lvl;
  logic          cnt_rise, set_a, set_b;
  logic          wr_lo, wr_hi, wr_md, wr_ct, hold;
  logic          gate_ok, src_ok, inc_a, inc_b, csel;
  tmr_mode_e     mode;

  tmr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({gate_pin_i, cnt_pin_i}),
    .q_o (pin_lvl)
  );

  tmr_rise u_rise (
    .clk_i, .rst_ni,
    .lvl_i  (pin_lvl[0]),
    .rise_o (cnt_rise)
  );

  assign wr_lo = wr_en_i && (wr_sel_i == SEL_LO);
  assign wr_hi = wr_en_i && (wr_sel_i == SEL_HI);
  assign wr_md = wr_en_i && (wr_sel_i == SEL_MODE);
  assign wr_ct = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign hold  = wr_lo | wr_hi;  // software load replaces counting

  assign mode    = tmr_mode_e'(mode_q[1:0]);
  assign csel    = mode_q[MB_CSEL];
  assign gate_ok = ~mode_q[MB_GATE] | pin_lvl[1];
  assign src_ok  = csel ? pend_q : tick_i;
  assign inc_a   = run_q & gate_ok & src_ok & ~hold;
  assign inc_b   = (mode == MD_SPLIT) & run_b_i & tick_i & ~hold;

  tmr_core #(.DW(DW), .PRE_BITS(PRE_BITS)) u_core (
    .mode_i  (mode),
    .tl_i    (tl_q),
    .th_i    (th_q),
    .inc_a_i (inc_a),
    .inc_b_i (inc_b),
    .tl_o    (tl_n),
    .th_o    (th_n),
    .set_a_o (set_a),
    .set_b_o (set_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tl_q    <= '0;
      th_q    <= '0;
      mode_q  <= '0;
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
      pend_q  <= 1'b0;
      ovf_b_q <= 1'b0;
    end else begin
      tl_q    <= wr_lo ? wr_data_i : tl_n;
      th_q    <= wr_hi ? wr_data_i : th_n;
      ovf_b_q <= set_b;
      if (wr_md) mode_q <= wr_data_i;
      if (wr_ct) run_q  <= wr_data_i[CB_RUN];
      // hardware set beats software clear
      if (set_a)      flag_q <= 1'b1;
      else if (wr_ct) flag_q <= wr_data_i[CB_FLAG];
      if (wr_md)                pend_q <= 1'b0;
      else if (cnt_rise)        pend_q <= 1'b1;
      else if (inc_a && csel)   pend_q <= 1'b0;
    end
  end

  assign tl_o    = tl_q;
  assign th_o    = th_q;
  assign mode_o  = mode_q;
  assign run_o   = run_q;
  assign ovf_o   = flag_q;
  assign ovf_b_o = ovf_b_q;
endmodule

// File: rtl/tmr_quad_chk.sv
module tmr_quad_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    wr_sel_i,
  input logic          run_b_i,
  input logic [DW-1:0] tl_o,
  input logic [DW-1:0] th_o,
  input logic [1:0]    mode_i,
  input logic          run_o,
  input logic          ovf_o,
  input logic          ovf_b_o
);
  // R3
  run_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !run_b_i && !wr_en_i) |=> ($stable(tl_o) && $stable(th_o)));

  // R9
  reload_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && !wr_en_i) |=> $stable(th_o));

  // R12
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(wr_en_i && wr_sel_i == 2'd3)) |=> ovf_o);

  // R10
  split_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd3) |=> !ovf_b_o);

  // R10
  hi_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_b_o |-> (th_o == '0));
endmodule

bind tmr_quad tmr_quad_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .run_b_i  (run_b_i),
  .tl_o     (tl_o),
  .th_o     (th_o),
  .mode_i   (mode_o[1:0]),
  .run_o    (run_o),
  .ovf_o    (ovf_o),
  .ovf_b_o  (ovf_b_o)
);

// File: tb/sim_tmr_quad.sv
`timescale 1ns/1ps
module sim_tmr_quad;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0, cnt_pin = 1'b0, gate_pin = 1'b0, run_b = 1'b0;
  logic [7:0] tl, th, mode;
  logic       run, ovf, ovf_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_quad u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .tick_i(tick), .cnt_pin_i(cnt_pin),
    .gate_pin_i(gate_pin), .run_b_i(run_b), .tl_o(tl), .th_o(th),
    .mode_o(mode), .run_o(run), .ovf_o(ovf), .ovf_b_o(ovf_b)
  );

  typedef struct packed {
    logic [7:0] md, tl, th, n, etl, eth;
    logic       fl;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h01, 8'hFE, 8'hFF, 8'd2, 8'h00, 8'h00, 1'b1},  // R8 wrap
    '{8'h01, 8'hFF, 8'h12, 8'd1, 8'h00, 8'h13, 1'b0},  // R8 carry
    '{8'h00, 8'h1E, 8'h05, 8'd2, 8'h00, 8'h06, 1'b0},  // R7 prescale roll
    '{8'h00, 8'h1F, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},  // R7 wrap
    '{8'h00, 8'hE3, 8'h10, 8'd3, 8'hE6, 8'h10, 1'b0},  // R7 upper bits kept
    '{8'h02, 8'hFE, 8'h80, 8'd3, 8'h81, 8'h80, 1'b1},  // R9 reload
    '{8'h02, 8'h10, 8'h00, 8'd5, 8'h15, 8'h00, 1'b0},  // R9 plain
    '{8'h03, 8'hFF, 8'h07, 8'd1, 8'h00, 8'h07, 1'b1}   // R10 low half
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_pin();
    cnt_pin = 1'b1; repeat (4) @(negedge clk);
    cnt_pin = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] md, input logic [7:0] l, input logic [7:0] h,
                       input logic [7:0] ct);
    wr(2'd3, 8'h00); wr(2'd2, md); wr(2'd0, l); wr(2'd1, h); wr(2'd3, ct);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tl", tl, 0); chk("R1 th", th, 0); chk("R1 mode", mode, 0);
    chk("R1 run", run, 0); chk("R1 ovf", ovf, 0); chk("R1 ovf_b", ovf_b, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 readback
    wr(2'd2, 8'h0D); chk("R2 mode", mode, 8'h0D);
    wr(2'd0, 8'hA5); chk("R2 tl", tl, 8'hA5);
    wr(2'd1, 8'h3C); chk("R2 th", th, 8'h3C);
    wr(2'd3, 8'h03); chk("R2 run", run, 1); chk("R2 flag", ovf, 1);

    for (int i = 0; i < 8; i++) begin
      setup(VEC[i].md, VEC[i].tl, VEC[i].th, 8'h01);
      ticks(int'(VEC[i].n));
      chk($sformatf("R7-9 vec%0d tl", i), tl, VEC[i].etl);
      chk($sformatf("R7-9 vec%0d th", i), th, VEC[i].eth);
      chk($sformatf("R7-9 vec%0d flag", i), ovf, VEC[i].fl);
    end

    // R3 run off
    setup(8'h01, 8'h20, 8'h00, 8'h00);
    ticks(4);
    chk("R3 tl", tl, 8'h20);

    // R4 gate low blocks, high counts
    setup(8'h09, 8'h20, 8'h00, 8'h01);
    ticks(4);
    chk("R4 gated tl", tl, 8'h20);
    gate_pin = 1'b1; repeat (4) @(negedge clk);
    ticks(3);
    chk("R4 open tl", tl, 8'h23);
    gate_pin = 1'b0;

    // R5 count pin
    setup(8'h05, 8'h00, 8'h00, 8'h01);
    ticks(10);
    chk("R5 tick ignored", tl, 8'h00);
    pulse_pin(); pulse_pin(); pulse_pin();
    repeat (6) @(negedge clk);
    chk("R5 edges", tl, 8'h03);

    // R5 pending edge held while stopped, then used
    setup(8'h05, 8'h00, 8'h00, 8'h00);
    pulse_pin(); repeat (4) @(negedge clk);
    chk("R5 held", tl, 8'h00);
    wr(2'd3, 8'h01); repeat (4) @(negedge clk);
    chk("R5 consumed", tl, 8'h01);

    // R6 mode write drops pending edge
    setup(8'h05, 8'h00, 8'h00, 8'h00);
    pulse_pin(); repeat (4) @(negedge clk);
    wr(2'd2, 8'h05);
    wr(2'd3, 8'h01); repeat (4) @(negedge clk);
    chk("R6 dropped", tl, 8'h00);

    // R10/R11 split: TL gated off, TH runs under run_b
    setup(8'h0B, 8'h05, 8'hFE, 8'h01);
    run_b = 1'b1;
    seen = 0;
    tick = 1'b1;
    repeat (2) begin @(negedge clk); if (ovf_b) seen++; end
    tick = 1'b0;
    @(negedge clk); if (ovf_b) seen++;
    run_b = 1'b0;
    chk("R11 th", th, 8'h00);
    chk("R11 tl held", tl, 8'h05);
    chk("R10 ovf_b pulses", seen, 1);
    chk("R10 own flag", ovf, 0);

    // R12 set beats clear, then clear works
    setup(8'h01, 8'hFF, 8'hFF, 8'h01);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R12 set wins", ovf, 1);
    chk("R12 wrap tl", tl, 8'h00);
    wr(2'd3, 8'h01);
    chk("R12 cleared", ovf, 0);

    // R12 byte write replaces count
    tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h40;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R12 write wins tl", tl, 8'h40);
    chk("R12 write wins th", th, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule